// File: doc/BRIEF.md
# DRAM Power-Down Entry/Exit Sequencer

This block sits on the controller side of a DDR2-style SDRAM interface and owns the clock-enable pin during power-down. When the scheduler raises an idle request while the command path is idle, the block lowers CKE and forces NOP/Deselect on the command bus. It picks the power-down flavour from the per-bank row-open flags sampled at that moment. It then holds the device down until a wake request arrives or the refresh-derived duration cap runs out, whichever comes first.

On exit the block raises CKE with a NOP on the same edge and keeps the command path muted for the exit latency that matches the flavour left. It then pulses a one-cycle ready flag and hands the command bus back. A status code and a DLL-off indication tell the rest of the controller what state the device is in. All timing values are run-time cycle counts. The duration cap is nine times the refresh-interval count.

Top module: `pd_seq`

## Requirements
- R1: After reset, cke is 1, cmd_nop is 0, ready is 0, dll_off is 0 and status is 0.
- R2: An entry happens only on an edge where idle_req and cmd_idle are both 1. In the first cycle after that edge, cke is 0 and cmd_nop is 1.
- R3: At entry, status becomes 1 (precharge power-down) if no bit of bank_open is set. Otherwise it becomes 2 when fast_exit is 1 (active, fast exit) and 3 when fast_exit is 0 (active, slow exit).
- R4: dll_off is 1 exactly while status is 1 or 3, and 0 in every other state.
- R5: cke stays 0 for at least t_cke cycles. A wake_req pulse that arrives before that minimum is held, and cke rises on the edge where the minimum is reached.
- R6: A wake_req sampled after the minimum low time raises cke on that same edge.
- R7: cke never stays 0 for more than 9*t_refi consecutive cycles. Without any wake request, cke rises after exactly 9*t_refi low cycles.
- R8: cke rises together with cmd_nop 1 and status 4. cmd_nop stays 1 for max(L,1) cycles counted from the first cycle cke is high. L is t_xp after status 1, t_xard after status 2 and t_xards after status 3.
- R9: ready is 1 for exactly one cycle: the first cycle with cmd_nop back at 0. In that cycle status is 0.
- R10: After cke rises, it stays 1 for at least t_cke cycles before a new entry, even when idle_req is held high.
- R11: wake_req while status is 0 has no effect. idle_req while cmd_idle is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_req | input | 1 | Request to enter power-down |
| cmd_idle | input | 1 | Command path has nothing pending |
| wake_req | input | 1 | Request to leave power-down |
| bank_open | input | NB | Per-bank row-open flags |
| fast_exit | input | 1 | Active power-down keeps DLL running (fast exit) |
| t_cke | input | CW | Minimum CKE pulse width, cycles |
| t_xp | input | CW | Exit latency after precharge power-down |
| t_xard | input | CW | Exit latency after fast-exit active power-down |
| t_xards | input | CW | Exit latency after slow-exit active power-down |
| t_refi | input | CW | Refresh interval, cycles; cap is nine times this |
| cke | output | 1 | Clock enable to the device |
| cmd_nop | output | 1 | 1 forces NOP/Deselect, 0 passes commands through |
| dll_off | output | 1 | Device DLL expected disabled |
| ready | output | 1 | One-cycle pulse when commands may resume |
| status | output | 3 | 0 active, 1 PD precharge, 2 PD active fast, 3 PD active slow, 4 exiting |

## Verification
The assertions guard properties that hold on every cycle. A low CKE always comes with a forced NOP. CKE falls only on a qualified request and rises with a NOP while the block reports exiting. Every low interval is at least t_cke long and never longer than the cap. Ready is a lone pulse with the bus released, and the DLL flag is never set while CKE is high. The bench scenarios cover what depends on the stimulus history: the flavour chosen from bank state and exit mode, and the exact low length for early, late and absent wake requests. They also cover the latency picked for each flavour, the held-off re-entry, and the inputs that must be ignored.

// File: rtl/pd_seq.sv
module pd_seq #(
  parameter int NB = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle_req,
  input  logic          cmd_idle,
  input  logic          wake_req,
  input  logic [NB-1:0] bank_open,
  input  logic          fast_exit,
  input  logic [CW-1:0] t_cke,
  input  logic [CW-1:0] t_xp,
  input  logic [CW-1:0] t_xard,
  input  logic [CW-1:0] t_xards,
  input  logic [CW-1:0] t_refi,
  output logic          cke,
  output logic          cmd_nop,
  output logic          dll_off,
  output logic          ready,
  output logic [2:0]    status
);
  localparam int LW = CW + 4;

  typedef enum logic [2:0] {
    S_ACT  = 3'd0,
    S_PRE  = 3'd1,
    S_AF   = 3'd2,
    S_AS   = 3'd3,
    S_EXIT = 3'd4
  } st_t;

  st_t st, pick;
  logic [LW-1:0] lo_cnt;
  logic [CW-1:0] hi_cnt, x_cnt, lat, exit_lat;
  logic wake_pend;

  wire [LW-1:0] refi_x = LW'(t_refi);
  wire [LW-1:0] cap = (refi_x << 3) + refi_x;
  wire lo_min = lo_cnt >= LW'(t_cke);
  wire go_exit = (lo_min && (wake_req || wake_pend)) || (lo_cnt >= cap);
  wire can_enter = idle_req && cmd_idle && (hi_cnt >= t_cke);
  wire [CW-1:0] hi_nxt = (hi_cnt == '1) ? hi_cnt : hi_cnt + 1'b1;

  assign pick = (~|bank_open) ? S_PRE : (fast_exit ? S_AF : S_AS);

  always_comb begin
    case (st)
      S_PRE:   exit_lat = t_xp;
      S_AF:    exit_lat = t_xard;
      default: exit_lat = t_xards;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_ACT;
      cke       <= 1'b1;
      cmd_nop   <= 1'b0;
      ready     <= 1'b0;
      lo_cnt    <= '0;
      hi_cnt    <= '1;
      x_cnt     <= '0;
      lat       <= '0;
      wake_pend <= 1'b0;
    end else begin
      ready <= 1'b0;
      case (st)
        S_ACT: begin
          if (can_enter) begin
            st        <= pick;
            cke       <= 1'b0;
            cmd_nop   <= 1'b1;
            lo_cnt    <= LW'(1);
            wake_pend <= 1'b0;
          end else begin
            hi_cnt <= hi_nxt;
          end
        end
        S_PRE, S_AF, S_AS: begin
          if (go_exit) begin
            st        <= S_EXIT;
            cke       <= 1'b1;
            hi_cnt    <= CW'(1);
            x_cnt     <= CW'(1);
            lat       <= exit_lat;
            wake_pend <= 1'b0;
          end else begin
            lo_cnt <= lo_cnt + 1'b1;
            if (wake_req) wake_pend <= 1'b1;
          end
        end
        S_EXIT: begin
          hi_cnt <= hi_nxt;
          if (x_cnt >= lat) begin
            st      <= S_ACT;
            cmd_nop <= 1'b0;
            ready   <= 1'b1;
          end else begin
            x_cnt <= x_cnt + 1'b1;
          end
        end
        default: st <= S_ACT;
      endcase
    end
  end

  assign status  = st;
  assign dll_off = (st == S_PRE) || (st == S_AS);

  logic [LW-1:0] chk_lo;
  always_ff @(posedge clk) begin
    if (!rst_n) chk_lo <= '0;
    else        chk_lo <= cke ? '0 : chk_lo + 1'b1;
  end

  // R2
  fall_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> $past(idle_req && cmd_idle));

  // R8
  nop_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> cmd_nop);

  // R8
  rise_with_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (cmd_nop && status == 3'd4));

  // R5
  low_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (chk_lo >= LW'(t_cke)));

  // R7
  low_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_lo <= cap);

  // R9
  ready_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cke && !cmd_nop && status == 3'd0));

  // R9
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  // R4
  dll_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dll_off |-> !cke);
endmodule

// File: tb/sim_pd_seq.sv
module sim_pd_seq;
  localparam int NB = 8;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idle_req = 1'b0, cmd_idle = 1'b1, wake_req = 1'b0, fast_exit = 1'b0;
  logic [NB-1:0] bank_open = '0;
  logic [CW-1:0] t_cke = 16'd2, t_xp = 16'd2, t_xard = 16'd2, t_xards = 16'd4, t_refi = 16'd4;
  logic cke, cmd_nop, dll_off, ready;
  logic [2:0] status;

  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;

  pd_seq #(.NB(NB), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .cmd_idle(cmd_idle),
    .wake_req(wake_req), .bank_open(bank_open), .fast_exit(fast_exit),
    .t_cke(t_cke), .t_xp(t_xp), .t_xard(t_xard), .t_xards(t_xards),
    .t_refi(t_refi), .cke(cke), .cmd_nop(cmd_nop), .dll_off(dll_off),
    .ready(ready), .status(status));

  always #4 clk = ~clk;

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      total++; bad++;
      $display("FAIL R5 watchdog actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_mode(input logic [NB-1:0] b, input bit f);
    return (b == '0) ? 1 : (f ? 2 : 3);
  endfunction

  function automatic int exp_dll(input int m);
    return (m == 1 || m == 3) ? 1 : 0;
  endfunction

  function automatic int exp_lat(input int m, input int xp, input int xa, input int xs);
    int v;
    v = (m == 1) ? xp : ((m == 2) ? xa : xs);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int exp_low(input int w, input int tc, input int cap);
    int v;
    v = (w > tc) ? w : tc;
    return (v < cap) ? v : cap;
  endfunction

  task automatic pd_cycle(input logic [NB-1:0] b, input bit f, input int w, input int tc,
                          input int xp, input int xa, input int xs, input int trf,
                          input bit reenter);
    int m, low, hi, cap, el;
    string tag;
    @(negedge clk);
    bank_open = b; fast_exit = f; cmd_idle = 1'b1; wake_req = 1'b0; idle_req = 1'b0;
    t_cke = CW'(tc); t_xp = CW'(xp); t_xard = CW'(xa); t_xards = CW'(xs); t_refi = CW'(trf);
    repeat (tc + 2) @(negedge clk);
    m = exp_mode(b, f);
    cap = 9 * trf;
    idle_req = 1'b1;
    @(negedge clk);
    idle_req = 1'b0;
    check(cke == 1'b0, "R2", int'(cke), 0);
    check(cmd_nop == 1'b1, "R2", int'(cmd_nop), 1);
    check(int'(status) == m, "R3", int'(status), m);
    check(int'(dll_off) == exp_dll(m), "R4", int'(dll_off), exp_dll(m));
    low = 1;
    while (cke == 1'b0) begin
      if (low == w) wake_req = 1'b1;
      @(negedge clk);
      wake_req = 1'b0;
      if (cke == 1'b0) low++;
    end
    el = exp_low(w, tc, cap);
    if (w > cap) tag = "R7";
    else if (w < tc) tag = "R5";
    else tag = "R6";
    check(low == el, tag, low, el);
    check(cmd_nop == 1'b1 && status == 3'd4, "R8", int'(status), 4);
    check(dll_off == 1'b0, "R4", int'(dll_off), 0);
    hi = 1;
    while (!ready) begin
      @(negedge clk);
      hi++;
    end
    check(hi - 1 == exp_lat(m, xp, xa, xs), "R8", hi - 1, exp_lat(m, xp, xa, xs));
    check(cmd_nop == 1'b0 && status == 3'd0, "R9", int'(status), 0);
    if (reenter) begin
      idle_req = 1'b1;
      @(negedge clk);
      check(ready == 1'b0, "R9", int'(ready), 0);
      if (cke == 1'b1) hi++;
      while (cke == 1'b1) begin
        @(negedge clk);
        if (cke == 1'b1) hi++;
      end
      idle_req = 1'b0;
      check(hi == ((hi - 0 > tc) ? hi : tc) && hi >= tc, "R10", hi, tc);
      wake_req = 1'b1;
      while (cke == 1'b0) @(negedge clk);
      wake_req = 1'b0;
      while (!ready) @(negedge clk);
      @(negedge clk);
    end else begin
      @(negedge clk);
      check(ready == 1'b0, "R9", int'(ready), 0);
    end
  endtask

  task automatic ignore_check();
    @(negedge clk);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    check(cke == 1'b1 && status == 3'd0, "R11", int'(status), 0);
    cmd_idle = 1'b0;
    idle_req = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(cke == 1'b1 && cmd_nop == 1'b0, "R11", int'(cke), 1);
    end
    idle_req = 1'b0;
    cmd_idle = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cke == 1'b1, "R1", int'(cke), 1);
    check(cmd_nop == 1'b0, "R1", int'(cmd_nop), 0);
    check(ready == 1'b0, "R1", int'(ready), 0);
    check(dll_off == 1'b0, "R1", int'(dll_off), 0);
    check(status == 3'd0, "R1", int'(status), 0);

    ignore_check();
    pd_cycle(8'h00, 1'b0, 2, 5, 3, 6, 9, 2, 1'b0);
    pd_cycle(8'h04, 1'b1, 9, 3, 3, 6, 9, 2, 1'b0);
    pd_cycle(8'h80, 1'b0, 1000, 2, 3, 6, 9, 2, 1'b0);
    pd_cycle(8'h01, 1'b1, 4, 4, 1, 1, 1, 1, 1'b1);
    pd_cycle(8'h00, 1'b0, 3, 6, 0, 2, 2, 3, 1'b1);

    for (int i = 0; i < 40; i++) begin
      logic [NB-1:0] b;
      int tc, w, trf;
      b = ($urandom % 2 == 0) ? '0 : NB'($urandom);
      tc = 1 + int'($urandom % 6);
      trf = 1 + int'($urandom % 5);
      w = ($urandom % 5 == 0) ? 1000 : 1 + int'($urandom % 50);
      pd_cycle(b, bit'($urandom % 2), w, tc,
               1 + int'($urandom % 8), 1 + int'($urandom % 8), 1 + int'($urandom % 8),
               trf, bit'($urandom % 2));
      if (i % 10 == 0) ignore_check();
    end
    finish_run();
  end
endmodule